// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

This bridge sits between one bus master and a word-addressed target bus. Each master access is decoded against two alias windows. An access that falls outside both windows is forwarded as it is. An access inside a window names one bit of one target word. An alias read fetches that word and returns only the named bit. An alias write reads the word, changes the named bit and writes the word back. The target bus stays locked from the read through the write, so that no other master can reach the word in between.

Both buses use a hold-until-acknowledged handshake. The master raises `m_req` and keeps its command steady until `m_ready` pulses for one cycle. The bridge raises `t_req` and keeps it up until `t_ack` pulses. Each alias window maps 32 MB of word-sized alias addresses onto 1 MB of target space, so every target bit has its own aligned word address.

Top module: `bitband_bridge`

## Requirements
- R1: An access outside both alias windows is forwarded to the target once, with the master's address, direction and write data unchanged. A forwarded read returns the target word, and a forwarded write returns zero data.
- R2: The data alias window spans 0x2200_0000 to 0x23FF_FFFF and targets base 0x2000_0000. The peripheral alias window spans 0x4200_0000 to 0x43FF_FFFF and targets base 0x4000_0000. For an alias address A with offset O = A − alias base, the target word is target base + 4·(O >> 7) and the bit index is A[6:2]. For example, 0x2200_0000 selects bit 0 of word 0x2000_0000.
- R3: An alias read returns the selected bit in bit 0 of `m_rdata`, with bits 31:1 at zero.
- R4: An alias write sets the selected bit of the target word to bit 0 of `m_wdata`. The other 31 bits keep their values.
- R5: For an alias write, `t_lock` is high on the target read and stays high, with no gap, through the target write that follows it. `t_lock` is low on forwarded accesses.
- R6: The master is stalled until its access is complete. `m_ready` pulses once per access: after one target transfer for a forwarded access or an alias read, and after two for an alias write. `t_req` stays high until `t_ack`.
- R7: An alias access whose address has A[1:0] ≠ 0 is answered with `m_err`=1 and `m_rdata`=0, and makes no target access, so the target word is unchanged.
- R8: While reset is held, and right after it, `m_ready`, `m_err`, `t_req` and `t_lock` are low.
- R9: An alias write answers with `m_err`=0 and `m_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request, held until m_ready |
| m_we | input | 1 | Master write when 1 |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data (bit 0 is used by alias writes) |
| m_rdata | output | 32 | Response data, valid with m_ready |
| m_ready | output | 1 | One-cycle completion pulse |
| m_err | output | 1 | Error response, valid with m_ready |
| t_req | output | 1 | Target request, held until t_ack |
| t_we | output | 1 | Target write when 1 |
| t_addr | output | 32 | Target word address |
| t_wdata | output | 32 | Target write data |
| t_rdata | input | 32 | Target read data, valid with t_ack |
| t_ack | input | 1 | Target one-cycle acknowledge |
| t_lock | output | 1 | Target bus lock for the read-modify-write |

## Verification
Forwarded reads and writes at plain addresses are mixed with alias reads and alias writes in both windows. The first alias address of a window shows whether the base mapping is right. Alias addresses with high bit numbers and non-zero word offsets show whether the offset shift and the bit field are taken from the correct address bits. Alias writes of a one and of a zero into words that hold both values are read back as whole words, which exposes a change to any neighbouring bit. A misaligned alias write is followed by a read-back, and the count of target transfers per access tells apart forwarded, single-transfer and locked two-transfer sequences.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int DW       = 32;
  localparam int AW       = 32;
  localparam int BIT_W    = $clog2(DW);
  localparam int TGT_LOG2 = 20;
  localparam int ALIAS_LOG2 = TGT_LOG2 + BIT_W;
  localparam int NWIN     = 2;

  localparam logic [AW-1:0] ALIAS_BASE [NWIN] = '{32'h2200_0000, 32'h4200_0000};
  localparam logic [AW-1:0] TGT_BASE   [NWIN] = '{32'h2000_0000, 32'h4000_0000};

  typedef enum logic [2:0] {
    S_IDLE,
    S_PASS,
    S_ARD,
    S_RRD,
    S_RWR,
    S_RESP
  } seq_state_t;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
(
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic             misalign,
  output logic [AW-1:0]    tgt_addr,
  output logic [BIT_W-1:0] bit_idx
);
  logic [NWIN-1:0] win_hit;
  logic [AW-1:0]   win_tgt [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_hit[w] = (addr[AW-1:ALIAS_LOG2] == ALIAS_BASE[w][AW-1:ALIAS_LOG2]);
    assign win_tgt[w] = TGT_BASE[w] |
                        {{(AW-TGT_LOG2){1'b0}}, addr[ALIAS_LOG2-1:BIT_W+2], 2'b00};
  end

  always_comb begin
    hit      = 1'b0;
    tgt_addr = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (win_hit[w]) begin
        hit      = 1'b1;
        tgt_addr = tgt_addr | win_tgt[w];
      end
    end
  end

  assign bit_idx  = addr[BIT_W+1:2];
  assign misalign = |addr[1:0];
endmodule

// File: rtl/bb_bitmerge.sv
module bb_bitmerge
  import bb_pkg::*;
(
  input  logic [DW-1:0]    old_word,
  input  logic [BIT_W-1:0] sel,
  input  logic             val,
  output logic [DW-1:0]    new_word,
  output logic             sel_bit
);
  logic [DW-1:0] pick;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign pick[i]     = (sel == BIT_W'(i));
    assign new_word[i] = pick[i] ? val : old_word[i];
  end

  assign sel_bit = |(pick & old_word);
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_req,
  input  logic             m_we,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  input  logic             dec_hit,
  input  logic             dec_misalign,
  input  logic [AW-1:0]    dec_tgt,
  input  logic [BIT_W-1:0] dec_bit,
  output logic [DW-1:0]    m_rdata,
  output logic             m_ready,
  output logic             m_err,
  output logic             t_req,
  output logic             t_we,
  output logic [AW-1:0]    t_addr,
  output logic [DW-1:0]    t_wdata,
  input  logic [DW-1:0]    t_rdata,
  input  logic             t_ack,
  output logic             t_lock
);
  seq_state_t       state_q, state_d;
  logic             we_q, we_d;
  logic             alias_q, alias_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [DW-1:0]    wdata_q, wdata_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [DW-1:0]    rsp_q, rsp_d;
  logic             err_q, err_d;
  logic [DW-1:0]    merged;
  logic             sel_bit;

  bb_bitmerge u_merge (
    .old_word (t_rdata),
    .sel      (bit_q),
    .val      (wdata_q[0]),
    .new_word (merged),
    .sel_bit  (sel_bit)
  );

  always_comb begin
    state_d = state_q;
    we_d    = we_q;
    alias_d = alias_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    bit_d   = bit_q;
    rsp_d   = rsp_q;
    err_d   = err_q;
    unique case (state_q)
      S_IDLE: begin
        if (m_req) begin
          we_d    = m_we;
          alias_d = dec_hit;
          bit_d   = dec_bit;
          wdata_d = m_wdata;
          err_d   = 1'b0;
          rsp_d   = '0;
          if (dec_hit && dec_misalign) begin
            err_d   = 1'b1;
            state_d = S_RESP;
          end else if (dec_hit) begin
            addr_d  = dec_tgt;
            state_d = m_we ? S_RRD : S_ARD;
          end else begin
            addr_d  = m_addr;
            state_d = S_PASS;
          end
        end
      end
      S_PASS: begin
        if (t_ack) begin
          rsp_d   = we_q ? '0 : t_rdata;
          state_d = S_RESP;
        end
      end
      S_ARD: begin
        if (t_ack) begin
          rsp_d   = {{(DW-1){1'b0}}, sel_bit};
          state_d = S_RESP;
        end
      end
      S_RRD: begin
        if (t_ack) begin
          wdata_d = merged;
          state_d = S_RWR;
        end
      end
      S_RWR: begin
        if (t_ack) begin
          rsp_d   = '0;
          state_d = S_RESP;
        end
      end
      S_RESP: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      we_q    <= 1'b0;
      alias_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      bit_q   <= '0;
      rsp_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      alias_q <= alias_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      bit_q   <= bit_d;
      rsp_q   <= rsp_d;
      err_q   <= err_d;
    end
  end

  assign t_req   = (state_q == S_PASS) || (state_q == S_ARD) ||
                   (state_q == S_RRD)  || (state_q == S_RWR);
  assign t_we    = ((state_q == S_PASS) && we_q) || (state_q == S_RWR);
  assign t_addr  = addr_q;
  assign t_wdata = wdata_q;
  assign t_lock  = (state_q == S_RRD) || (state_q == S_RWR);
  assign m_ready = (state_q == S_RESP);
  assign m_err   = m_ready && err_q;
  assign m_rdata = m_ready ? rsp_q : '0;

  // R5: lock is continuous from the locked read into the locked write
  a_r5_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    (t_lock && t_ack && !t_we) |=> (t_lock && t_req && t_we));

  // R4: the write-back differs from the word read in at most one bit
  a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (t_lock && t_ack && !t_we) |=> ($countones(t_wdata ^ $past(t_rdata)) <= 1));

  // R6: a target request is held until acknowledged
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (t_req && !t_ack) |=> t_req);

  // R6: a completion pulse lasts one cycle
  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> !m_ready);

  // R7: an error response carries no data
  a_r7_err_resp: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (m_ready && (m_rdata == '0)));

  // R3: alias read data is confined to bit 0
  a_r3_alias_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready && alias_q && !we_q) |-> (m_rdata[DW-1:1] == '0));
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [31:0]   m_addr,
  input  logic [31:0]   m_wdata,
  output logic [31:0]   m_rdata,
  output logic          m_ready,
  output logic          m_err,
  output logic          t_req,
  output logic          t_we,
  output logic [31:0]   t_addr,
  output logic [31:0]   t_wdata,
  input  logic [31:0]   t_rdata,
  input  logic          t_ack,
  output logic          t_lock
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             dec_hit;
  logic             dec_misalign;
  logic [AW-1:0]    dec_tgt;
  logic [BIT_W-1:0] dec_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bb_decode u_dec (
    .addr     (m_addr),
    .hit      (dec_hit),
    .misalign (dec_misalign),
    .tgt_addr (dec_tgt),
    .bit_idx  (dec_bit)
  );

  bb_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .m_req        (m_req),
    .m_we         (m_we),
    .m_addr       (m_addr),
    .m_wdata      (m_wdata),
    .dec_hit      (dec_hit),
    .dec_misalign (dec_misalign),
    .dec_tgt      (dec_tgt),
    .dec_bit      (dec_bit),
    .m_rdata      (m_rdata),
    .m_ready      (m_ready),
    .m_err        (m_err),
    .t_req        (t_req),
    .t_we         (t_we),
    .t_addr       (t_addr),
    .t_wdata      (t_wdata),
    .t_rdata      (t_rdata),
    .t_ack        (t_ack),
    .t_lock       (t_lock)
  );
endmodule

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
  logic        clk;
  logic        rst_n;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        m_ready, m_err;
  logic        t_req, t_we, t_lock;
  logic [31:0] t_addr, t_wdata, t_rdata;
  logic        t_ack;

  bitband_bridge dut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
    .t_req(t_req), .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata),
    .t_rdata(t_rdata), .t_ack(t_ack), .t_lock(t_lock)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] rdata;
    logic        err;
    logic [1:0]  nacc;
    logic [7:0]  req;
  } exp_t;

  exp_t        expq[$];
  logic [31:0] mem    [128];
  logic [31:0] shadow [128];
  int          checks = 0;
  int          errors = 0;
  int          acks   = 0;
  logic        cur_alias = 1'b0;
  logic        done = 1'b0;
  int          cycles = 0;

  function automatic int idx(input logic [31:0] a);
    return {a[30], a[7:2]};
  endfunction

  // target model: acknowledge one cycle after each request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_ack   <= 1'b0;
      t_rdata <= '0;
    end else begin
      t_ack <= t_req && !t_ack;
      if (t_req && !t_ack) begin
        if (t_we) mem[idx(t_addr)] <= t_wdata;
        else      t_rdata <= mem[idx(t_addr)];
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (t_ack) acks++;
    if (t_req && t_we)
      chk(t_lock == cur_alias, "R5 lock on target write", 32'(t_lock), 32'(cur_alias));
    if (m_ready) begin
      exp_t e;
      if (expq.size() == 0) begin
        chk(1'b0, "R6 unexpected response", 32'd1, 32'd0);
      end else begin
        e = expq.pop_front();
        chk(m_rdata == e.rdata, $sformatf("R%0d data", e.req), m_rdata, e.rdata);
        chk(m_err == e.err, $sformatf("R%0d err", e.req), 32'(m_err), 32'(e.err));
        chk(acks == int'(e.nacc), $sformatf("R6 transfers (R%0d)", e.req), 32'(acks), 32'(e.nacc));
      end
      acks = 0;
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd, input int rq);
    exp_t e;
    logic        al;
    logic [31:0] tgt;
    int          b;
    al = (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
    tgt = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
    tgt = tgt + ((a - {a[31:25], 25'd0}) >> 7) * 4;
    b = int'(a[6:2]);
    e.req = 8'(rq);
    e.err = 1'b0;
    e.rdata = '0;
    if (al && a[1:0] != 2'b00) begin
      e.err = 1'b1; e.nacc = 2'd0;
    end else if (al && we) begin
      shadow[idx(tgt)][b] = wd[0]; e.nacc = 2'd2;
    end else if (al) begin
      e.rdata = {31'd0, shadow[idx(tgt)][b]}; e.nacc = 2'd1;
    end else if (we) begin
      shadow[idx(a)] = wd; e.nacc = 2'd1;
    end else begin
      e.rdata = shadow[idx(a)]; e.nacc = 2'd1;
    end
    expq.push_back(e);
    @(negedge clk);
    cur_alias = al && we;
    m_req = 1'b1; m_we = we; m_addr = a; m_wdata = wd;
    do @(negedge clk); while (!m_ready);
    m_req = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]    = 32'h1234_5678 ^ (i * 32'h0101_0101);
      shadow[i] = 32'h1234_5678 ^ (i * 32'h0101_0101);
    end
    m_req = 1'b0; m_we = 1'b0; m_addr = '0; m_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!m_ready && !m_err && !t_req && !t_lock, "R8 reset outputs",
        {28'd0, m_ready, m_err, t_req, t_lock}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!m_ready && !t_req && !t_lock, "R8 after reset",
        {29'd0, m_ready, t_req, t_lock}, 32'd0);

    access(1'b0, 32'h2000_0010, 32'd0, 1);            // R1 forwarded read
    access(1'b1, 32'h2000_0010, 32'hA5A5_0F0F, 1);    // R1 forwarded write
    access(1'b0, 32'h2000_0010, 32'd0, 1);            // R1 read back
    access(1'b0, 32'h2200_0000, 32'd0, 2);            // R2 base alias, bit 0 of word 0
    access(1'b0, 32'h2200_0214, 32'd0, 3);            // R3 bit 5 of 0x2000_0010
    access(1'b0, 32'h2200_020C, 32'd0, 3);            // R3 bit 3
    access(1'b1, 32'h2200_0214, 32'hFFFF_FFFF, 4);    // R4 set bit 5
    access(1'b0, 32'h2000_0010, 32'd0, 4);            // R4 whole word read back
    access(1'b1, 32'h2200_027C, 32'hFFFF_FFFE, 9);    // R9 clear bit 31
    access(1'b0, 32'h2000_0010, 32'd0, 4);            // R4 neighbours kept
    access(1'b1, 32'h4200_011C, 32'h0000_0001, 2);    // R2 peripheral window bit 7 of 0x4000_0008
    access(1'b0, 32'h4000_0008, 32'd0, 2);            // R2 peripheral word read back
    access(1'b0, 32'h43FF_FFFC, 32'd0, 2);            // R2 last alias of window (bit 31, word 0xFFFFC)
    access(1'b1, 32'h2200_07E0, 32'h0000_0000, 4);    // R4 clear bit 24 of 0x2000_003C
    access(1'b0, 32'h2000_003C, 32'd0, 4);
    access(1'b1, 32'h2200_0215, 32'h0000_0000, 7);    // R7 misaligned alias write
    access(1'b0, 32'h2000_0010, 32'd0, 7);            // R7 word unchanged
    access(1'b0, 32'h4200_0002, 32'd0, 7);            // R7 misaligned alias read
    access(1'b1, 32'h4000_0020, 32'hDEAD_BEEF, 5);    // R5 forwarded write keeps lock low
    access(1'b0, 32'h4200_0400, 32'd0, 5);            // R5/R3 alias read of 0x4000_0020 bit 0

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R6 all responses seen", 32'(expq.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule